// File: doc/BRIEF.md
# Hardwired Instruction Cycle Sequencer

This block is the control unit of a small accumulator-style processor, together with the register-transfer datapath it steers. It holds a program counter, a memory address register, a memory buffer register, an instruction register and one working register. Every instruction passes through a fixed series of sub-cycles, and each sub-cycle has exactly three timed steps. A fetch always comes first. An optional indirect sub-cycle resolves a pointer. An execute sub-cycle follows. When an enabled request is pending, an interrupt-entry sub-cycle comes last. The control strobes for every step are decoded in hardwired logic from the sub-cycle code, the step code and the opcode.

The memory is external and word-addressed. An address presented on `mem_addr` is registered by the memory at a clock edge, and the read word is returned on `mem_rdata` during the next cycle. A write happens at the edge that ends a cycle in which `mem_we` is high. Only the interrupt-entry sub-cycle saves state, and it saves only the return address. Saving any other context is left to the handler code. All internal registers are exposed as observation outputs.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is asserted, and at the first cycle after it is released: PC = RESET_PC, MAR = MBR = IR = R1 = 0, interrupt enable = 1, sub-cycle code = 00 and step code = 00.
- R2: Fetch (code 00) behaves as follows. Step T1 (code 00) loads MAR from PC. Step T2 (code 01) loads MBR from memory at MAR and adds 1 to PC, wrapping. Step T3 (code 10) loads IR from MBR.
- R3: No step both loads and reads the same register. In particular, MBR is never loaded in the step that moves it into IR or R1 or writes it to memory. `mem_we` is high only in step T3, with `mem_addr` equal to MAR and `mem_wdata` equal to MBR.
- R4: The instruction word is {opcode[15:12], indirect[11], address[10:0]}. When bit 11 is set, fetch is followed by the indirect sub-cycle (code 01). Its T1 loads MAR from IR[10:0]. Its T2 reads memory into MBR. Its T3 replaces IR[10:0] with MBR[10:0] and leaves IR[15:11] unchanged.
- R5: ADD (opcode 3) runs T1 MAR←IR[10:0], T2 MBR←memory, T3 R1←R1+MBR, with the sum taken modulo 2^16.
- R6: LOAD (opcode 1) runs the same steps as ADD, except that T3 sets R1←MBR.
- R7: STORE (opcode 2) runs T1 MAR←IR[10:0], T2 MBR←R1, T3 writes MBR to memory at MAR.
- R8: JUMP (opcode 4) loads PC from IR[10:0] in T1. Its T2 and T3 change no register.
- R9: When execute T3 ends with the interrupt enable set and `irq_req` high, the interrupt sub-cycle (code 11) follows and the enable is cleared. Its T1 sets MBR←PC, zero-extended. Its T2 sets MAR←SAVE_ADDR and PC←HANDLER_ADDR. Its T3 writes MBR to memory. The next sub-cycle is fetch.
- R10: EI (opcode 5) sets the interrupt enable in execute T1, so a pending request is taken at the end of that same execute sub-cycle.
- R11: HALT (opcode 0) freezes the sequencer in execute T1 with `halted` high. No register changes, no memory write happens and requests are ignored until reset.
- R12: Opcodes 6 to 15 change no register during execute.
- R13: Steps always run T1, T2, T3 and then back to T1. The sub-cycle code changes only at the end of T3. Execute follows indirect. Fetch follows interrupt, and also follows an execute sub-cycle that takes no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Word read from memory, valid the cycle after its address |
| mem_addr | output | 11 | Memory address (registered by the memory at each edge) |
| mem_wdata | output | 16 | Write data (MBR) |
| mem_we | output | 1 | Memory write strobe |
| pc_o | output | 11 | Program counter |
| mar_o | output | 11 | Memory address register |
| mbr_o | output | 16 | Memory buffer register |
| ir_o | output | 16 | Instruction register |
| r1_o | output | 16 | Working register |
| ie_o | output | 1 | Interrupt enable flag |
| cyc_o | output | 2 | Sub-cycle code: 00 fetch, 01 indirect, 10 execute, 11 interrupt |
| step_o | output | 2 | Step code: 00 T1, 01 T2, 10 T3 |
| halted | output | 1 | High while frozen on HALT |

## Verification
A random program mixes every opcode except HALT, sets the indirect bit at random and targets random addresses. A random request line runs alongside it. This separates the direct and indirect paths and tells taken interrupts apart from ignored ones, depending on whether the enable is set. A reference model compares every register after every step. A directed program then checks several corner cases. It checks a 16-bit add that wraps. It checks an indirect jump that returns from the handler through the saved address. It checks a request that is already pending when EI executes, which must enter the handler at once. Finally, a request held high during HALT must leave every register frozen.

// File: rtl/seqr_pkg.sv
`timescale 1ns/1ps
package seqr_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INTR  = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    STEP_T1 = 2'b00,
    STEP_T2 = 2'b01,
    STEP_T3 = 2'b10
  } step_e;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'd4;
  localparam logic [OPC_W-1:0] OP_EI    = 4'd5;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_r1;
    logic ir_mbr;
    logic iraddr_mbr;
    logic pc_inc;
    logic pc_ir;
    logic pc_hnd;
    logic r1_mbr;
    logic r1_add;
    logic mem_we;
    logic ie_set;
    logic ie_clr;
  } ctrl_t;
endpackage

// File: rtl/seqr_timing.sv
`timescale 1ns/1ps
module seqr_timing
  import seqr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  freeze,
  input  logic  ind_flag,
  input  logic  go_intr,
  output cyc_e  cyc_q,
  output step_e step_q
);
  cyc_e  cyc_d;
  step_e step_d;
  logic  adv;

  always_comb begin
    adv    = !freeze;
    cyc_d  = cyc_q;
    unique case (step_q)
      STEP_T1: step_d = STEP_T2;
      STEP_T2: step_d = STEP_T3;
      default: step_d = STEP_T1;
    endcase
    if (step_q == STEP_T3) begin
      unique case (cyc_q)
        CYC_FETCH: cyc_d = ind_flag ? CYC_IND : CYC_EXEC;
        CYC_IND:   cyc_d = CYC_EXEC;
        CYC_EXEC:  cyc_d = go_intr ? CYC_INTR : CYC_FETCH;
        default:   cyc_d = CYC_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CYC_FETCH;
      step_q <= STEP_T1;
    end else if (adv) begin
      cyc_q  <= cyc_d;
      step_q <= step_d;
    end
  end

  AST_STEP_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_q inside {STEP_T1, STEP_T2, STEP_T3}); // R13
  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && step_q == STEP_T3) |=> step_q == STEP_T1); // R13
  AST_CYC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != STEP_T3) |=> $stable(cyc_q)); // R13
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(step_q) && $stable(cyc_q))); // R11
  AST_IND_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CYC_IND && step_q == STEP_T1) |-> $past(cyc_q) == CYC_FETCH); // R4
endmodule

// File: rtl/seqr_decode.sv
`timescale 1ns/1ps
module seqr_decode
  import seqr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_e             cyc,
  input  step_e            step,
  input  logic [OPC_W-1:0] op,
  input  logic             ie,
  input  logic             irq_req,
  output ctrl_t            ctrl,
  output logic             halt,
  output logic             go_intr
);
  logic mem_ref;

  always_comb begin
    ctrl    = '0;
    mem_ref = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
    halt    = (cyc == CYC_EXEC) && (op == OP_HALT);
    go_intr = (cyc == CYC_EXEC) && (step == STEP_T3) && !halt && ie && irq_req;
    unique case (cyc)
      CYC_FETCH: begin
        ctrl.mar_pc  = (step == STEP_T1);
        ctrl.mbr_mem = (step == STEP_T2);
        ctrl.pc_inc  = (step == STEP_T2);
        ctrl.ir_mbr  = (step == STEP_T3);
      end
      CYC_IND: begin
        ctrl.mar_ir     = (step == STEP_T1);
        ctrl.mbr_mem    = (step == STEP_T2);
        ctrl.iraddr_mbr = (step == STEP_T3);
      end
      CYC_EXEC: begin
        ctrl.mar_ir  = (step == STEP_T1) && mem_ref;
        ctrl.pc_ir   = (step == STEP_T1) && (op == OP_JUMP);
        ctrl.ie_set  = (step == STEP_T1) && (op == OP_EI);
        ctrl.mbr_mem = (step == STEP_T2) && ((op == OP_LOAD) || (op == OP_ADD));
        ctrl.mbr_r1  = (step == STEP_T2) && (op == OP_STORE);
        ctrl.r1_mbr  = (step == STEP_T3) && (op == OP_LOAD);
        ctrl.r1_add  = (step == STEP_T3) && (op == OP_ADD);
        ctrl.mem_we  = (step == STEP_T3) && (op == OP_STORE);
        ctrl.ie_clr  = go_intr;
      end
      default: begin
        ctrl.mbr_pc   = (step == STEP_T1);
        ctrl.mar_save = (step == STEP_T2);
        ctrl.pc_hnd   = (step == STEP_T2);
        ctrl.mem_we   = (step == STEP_T3);
      end
    endcase
  end

  AST_MBR_RW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mbr_mem || ctrl.mbr_pc || ctrl.mbr_r1) |->
    !(ctrl.ir_mbr || ctrl.iraddr_mbr || ctrl.r1_mbr || ctrl.r1_add || ctrl.mem_we)); // R3
  AST_MAR_RW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mar_pc || ctrl.mar_ir || ctrl.mar_save) |-> !(ctrl.mbr_mem || ctrl.mem_we)); // R3
  AST_ONE_MAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl.mar_pc, ctrl.mar_ir, ctrl.mar_save}) <= 1); // R3
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (ctrl == '0 && !go_intr)); // R11
endmodule

// File: rtl/seqr_datapath.sv
`timescale 1ns/1ps
module seqr_datapath
  import seqr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC     = '0,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = '1,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] r1_q,
  output logic              ie_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_d, mar_d;
  logic [DATA_W-1:0] mbr_d, ir_d, r1_d;
  logic              pc_en, mar_en, mbr_en, ir_en, r1_en, ie_en;

  always_comb begin
    pc_en  = ctrl.pc_inc | ctrl.pc_ir | ctrl.pc_hnd;
    mar_en = ctrl.mar_pc | ctrl.mar_ir | ctrl.mar_save;
    mbr_en = ctrl.mbr_mem | ctrl.mbr_pc | ctrl.mbr_r1;
    ir_en  = ctrl.ir_mbr | ctrl.iraddr_mbr;
    r1_en  = ctrl.r1_mbr | ctrl.r1_add;
    ie_en  = ctrl.ie_set | ctrl.ie_clr;

    if (ctrl.pc_inc)      pc_d = pc_q + PC_STEP;
    else if (ctrl.pc_ir)  pc_d = ir_q[ADDR_W-1:0];
    else                  pc_d = HANDLER_ADDR;

    if (ctrl.mar_pc)      mar_d = pc_q;
    else if (ctrl.mar_ir) mar_d = ir_q[ADDR_W-1:0];
    else if (ctrl.mar_save) mar_d = SAVE_ADDR;
    else                  mar_d = mar_q;

    if (ctrl.mbr_mem)     mbr_d = mem_rdata;
    else if (ctrl.mbr_pc) mbr_d = {{PAD_W{1'b0}}, pc_q};
    else                  mbr_d = r1_q;

    if (ctrl.ir_mbr)      ir_d = mbr_q;
    else                  ir_d = {ir_q[DATA_W-1:ADDR_W], mbr_q[ADDR_W-1:0]};

    if (ctrl.r1_add)      r1_d = r1_q + mbr_q;
    else                  r1_d = mbr_q;
  end

  assign mem_addr  = mar_d;
  assign mem_wdata = mbr_q;
  assign mem_we    = ctrl.mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      r1_q  <= '0;
      ie_q  <= 1'b1;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mbr_en) mbr_q <= mbr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (r1_en)  r1_q  <= r1_d;
      if (ie_en)  ie_q  <= ctrl.ie_set;
    end
  end

  AST_WRITE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == mar_q && mem_wdata == mbr_q)); // R3
  AST_IE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ie_clr |=> !ie_q); // R9
  AST_IR_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.iraddr_mbr |=> ir_q[DATA_W-1:ADDR_W] == $past(ir_q[DATA_W-1:ADDR_W])); // R4
endmodule

// File: rtl/instr_cycle_seq.sv
`timescale 1ns/1ps
module instr_cycle_seq
  import seqr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] RESET_PC     = '0,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h7F0,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h020,
  localparam int DATA_W = OPC_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] r1_o,
  output logic              ie_o,
  output logic [1:0]        cyc_o,
  output logic [1:0]        step_o,
  output logic              halted
);
  cyc_e  cyc;
  step_e step;
  ctrl_t ctrl;
  logic  halt, go_intr;

  seqr_timing u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (halt),
    .ind_flag (mbr_o[ADDR_W]),
    .go_intr  (go_intr),
    .cyc_q    (cyc),
    .step_q   (step)
  );

  seqr_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc     (cyc),
    .step    (step),
    .op      (ir_o[DATA_W-1 -: OPC_W]),
    .ie      (ie_o),
    .irq_req (irq_req),
    .ctrl    (ctrl),
    .halt    (halt),
    .go_intr (go_intr)
  );

  seqr_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .RESET_PC     (RESET_PC),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .pc_q      (pc_o),
    .mar_q     (mar_o),
    .mbr_q     (mbr_o),
    .ir_q      (ir_o),
    .r1_q      (r1_o),
    .ie_q      (ie_o),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  assign cyc_o  = cyc;
  assign step_o = step;
  assign halted = halt;

  AST_FETCH_MAR_GETS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_FETCH && step == STEP_T1) |=> mar_o == $past(pc_o)); // R2
  AST_FETCH_PC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_FETCH && step == STEP_T2) |=> pc_o == $past(pc_o) + ADDR_W'(1)); // R2
  AST_INTR_VECTORS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_INTR && step == STEP_T3) |-> (pc_o == HANDLER_ADDR && mar_o == SAVE_ADDR && mem_we)); // R9
  AST_INTR_NO_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_INTR) |-> !ie_o); // R9
endmodule

// File: tb/instr_cycle_seq_bench.sv
`timescale 1ns/1ps
module instr_cycle_seq_bench;
  localparam logic [10:0] SAVE = 11'h7F0;
  localparam logic [10:0] HND  = 11'h020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic [15:0] rdata;
  logic [10:0] mem_addr, pc_o, mar_o;
  logic [15:0] mem_wdata, mbr_o, ir_o, r1_o;
  logic mem_we, ie_o, halted;
  logic [1:0] cyc_o, step_o;

  always #2.5 clk = ~clk;

  instr_cycle_seq #(.SAVE_ADDR(SAVE), .HANDLER_ADDR(HND)) u_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq), .mem_rdata(rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .pc_o(pc_o), .mar_o(mar_o), .mbr_o(mbr_o), .ir_o(ir_o), .r1_o(r1_o),
    .ie_o(ie_o), .cyc_o(cyc_o), .step_o(step_o), .halted(halted)
  );

  logic [15:0] mem [0:2047];
  logic [15:0] ref_mem [0:2047];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    rdata <= mem[mem_addr];
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit track = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R11";
      4'd1: return "R6";
      4'd2: return "R7";
      4'd3: return "R5";
      4'd4: return "R8";
      4'd5: return "R10";
      default: return "R12";
    endcase
  endfunction

  // reference model, written from the step tables of the requirements
  logic [10:0] e_pc, e_mar;
  logic [15:0] e_mbr, e_ir, e_r1;
  logic e_ie;
  logic [1:0] e_cyc, e_step;
  string e_tag = "R1";

  always @(posedge clk or negedge rst_n) begin : ref_model
    logic [3:0] op;
    logic [10:0] ea;
    logic [1:0] nc;
    if (!rst_n) begin
      e_pc = '0; e_mar = '0; e_mbr = '0; e_ir = '0; e_r1 = '0;
      e_ie = 1'b1; e_cyc = 2'd0; e_step = 2'd0; e_tag = "R1";
    end else begin
      op = e_ir[15:12];
      ea = e_ir[10:0];
      nc = e_cyc;
      if (!(e_cyc == 2'd2 && op == 4'd0)) begin
        case (e_cyc)
          2'd0: begin
            e_tag = "R2";
            case (e_step)
              2'd0: e_mar = e_pc;
              2'd1: begin e_mbr = ref_mem[e_mar]; e_pc = e_pc + 11'd1; end
              default: begin e_ir = e_mbr; nc = e_mbr[11] ? 2'd1 : 2'd2; end
            endcase
          end
          2'd1: begin
            e_tag = "R4";
            case (e_step)
              2'd0: e_mar = ea;
              2'd1: e_mbr = ref_mem[e_mar];
              default: begin e_ir = {e_ir[15:11], e_mbr[10:0]}; nc = 2'd2; end
            endcase
          end
          2'd2: begin
            e_tag = op_tag(op);
            case (e_step)
              2'd0: begin
                if (op == 4'd1 || op == 4'd2 || op == 4'd3) e_mar = ea;
                else if (op == 4'd4) e_pc = ea;
                else if (op == 4'd5) e_ie = 1'b1;
              end
              2'd1: begin
                if (op == 4'd1 || op == 4'd3) e_mbr = ref_mem[e_mar];
                else if (op == 4'd2) e_mbr = e_r1;
              end
              default: begin
                if (op == 4'd1) e_r1 = e_mbr;
                else if (op == 4'd3) e_r1 = e_r1 + e_mbr;
                else if (op == 4'd2) ref_mem[e_mar] = e_mbr;
                if (e_ie && irq) begin nc = 2'd3; e_ie = 1'b0; end
                else nc = 2'd0;
              end
            endcase
          end
          default: begin
            e_tag = "R9";
            case (e_step)
              2'd0: e_mbr = {5'd0, e_pc};
              2'd1: begin e_mar = SAVE; e_pc = HND; end
              default: begin ref_mem[e_mar] = e_mbr; nc = 2'd0; end
            endcase
          end
        endcase
        if (e_step == 2'd2) begin e_cyc = nc; e_step = 2'd0; end
        else e_step = e_step + 2'd1;
      end
    end
  end

  always @(negedge clk) begin : step_compare
    logic ewe;
    if (track && rst_n) begin
      ewe = (e_cyc == 2'd2 && e_step == 2'd2 && e_ir[15:12] == 4'd2) ||
            (e_cyc == 2'd3 && e_step == 2'd2);
      chk("R13", "cyc", 32'(cyc_o), 32'(e_cyc));
      chk("R13", "step", 32'(step_o), 32'(e_step));
      chk(e_tag, "pc", 32'(pc_o), 32'(e_pc));
      chk(e_tag, "mar", 32'(mar_o), 32'(e_mar));
      chk(e_tag, "mbr", 32'(mbr_o), 32'(e_mbr));
      chk(e_tag, "ir", 32'(ir_o), 32'(e_ir));
      chk(e_tag, "r1", 32'(r1_o), 32'(e_r1));
      chk(e_tag, "ie", 32'(ie_o), 32'(e_ie));
      chk("R11", "halted", 32'(halted), 32'(e_cyc == 2'd2 && e_ir[15:12] == 4'd0));
      chk("R3", "mem_we", 32'(mem_we), 32'(ewe));
      if (ewe) begin
        chk("R3", "mem_addr", 32'(mem_addr), 32'(e_mar));
        chk("R3", "mem_wdata", 32'(mem_wdata), 32'(e_mbr));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pc", 32'(pc_o), 32'h0);
    chk("R1", "cyc", 32'(cyc_o), 32'h0);
    chk("R1", "step", 32'(step_o), 32'h0);
    chk("R1", "ie", 32'(ie_o), 32'h1);
    chk("R1", "r1", 32'(r1_o), 32'h0);
    chk("R1", "ir", 32'(ir_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : main
    logic [15:0] w;
    void'($urandom(32'd617));
    // random program, any opcode except HALT, random indirect bits
    for (int a = 0; a < 2048; a++) begin
      w = 16'($urandom);
      if (w[15:12] == 4'd0) w[15:12] = 4'd3;
      mem[a] = w;
      ref_mem[a] = w;
    end
    do_reset();
    track = 1'b1;
    repeat (4000) begin
      irq = ($urandom_range(7) == 0);
      @(negedge clk);
    end
    track = 1'b0;
    irq = 1'b0;

    // directed program: pending request, indirect return, wrap add, EI, HALT
    for (int a = 0; a < 2048; a++) begin
      mem[a] = 16'h0;
      ref_mem[a] = 16'h0;
    end
    mem[11'h000] = 16'h1100;  // LOAD 0x100
    mem[11'h001] = 16'h3901;  // ADD indirect via 0x101
    mem[11'h002] = 16'h2103;  // STORE 0x103
    mem[11'h003] = 16'h4010;  // JUMP 0x010
    mem[11'h010] = 16'h7000;  // unassigned opcode
    mem[11'h011] = 16'h5000;  // EI
    mem[11'h012] = 16'h0000;  // HALT
    mem[11'h020] = 16'h4FF0;  // handler: JUMP indirect via save slot
    mem[11'h100] = 16'h7FFF;
    mem[11'h101] = 16'h0102;
    mem[11'h102] = 16'h8003;
    for (int a = 0; a < 2048; a++) ref_mem[a] = mem[a];
    irq = 1'b1;
    do_reset();
    track = 1'b1;
    repeat (150) @(negedge clk);
    chk("R11", "halted after program", 32'(halted), 32'h1);
    chk("R5", "r1 wrapped sum", 32'(r1_o), 32'h0002);
    chk("R7", "stored word", 32'(mem[11'h103]), 32'h0002);
    chk("R10", "return slot after EI", 32'(mem[SAVE]), 32'h0012);
    chk("R9", "ie cleared by entry", 32'(ie_o), 32'h0);
    chk("R8", "pc past HALT", 32'(pc_o), 32'h013);
    repeat (20) @(negedge clk);
    chk("R11", "pc frozen under request", 32'(pc_o), 32'h013);
    chk("R11", "step frozen", 32'(step_o), 32'h0);
    chk("R12", "r1 unchanged", 32'(r1_o), 32'h0002);
    track = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule